// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Trigger

This block sits beside a pair of 16-entry FIFOs, one carrying received data and one carrying data waiting to be sent. It does not hold any data itself. Each cycle it sees how many entries each FIFO holds. When a count passes through a chosen fill point, it raises an interrupt for that FIFO. The receive side fires as the FIFO fills up through its threshold. The transmit side fires as its FIFO drains down through its threshold.

Each side has a 3-bit level select that picks one of five thresholds, set at eighths of the depth. The receive side fires on the way up, at 1/8, 1/4, 1/2, 3/4 and 7/8 of the depth. The transmit side fires on the way down, at 7/8, 3/4, 1/2, 1/4 and 1/8. A crossing sets a sticky raw status bit. Software acknowledges it with a one-cycle clear strobe. The interrupt pin that leaves the block is the raw bit gated by an arm (mask) bit.

The trigger responds to movement, not to level. A FIFO that stays above its receive threshold, or below its transmit threshold, after an acknowledge does not fire again until the count leaves that region and comes back. No pins here carry a data stream, so the block has no valid/ready handshake. All of its inputs and outputs are plain control and status pins.

Top module: `fill_irq_trigger`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both raw status bits and both interrupt outputs are 0. The stored previous counts reset to 0, which means empty.
- R2: The receive raw bit is set at the clock edge after the receive count moves from below threshold T to T or above. T depends on the level select: code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 12 and code 4 gives 14.
- R3: The transmit raw bit is set at the clock edge after the transmit count moves from above threshold T to T or below. T depends on the level select: code 0 gives 14, code 1 gives 12, code 2 gives 8, code 3 gives 4 and code 4 gives 2.
- R4: A crossing that skips several entries in one cycle sets the raw bit, for example receive 0 to 16 or transmit 16 to 0.
- R5: The raw bit is not set when the count stays on the far side of the threshold, when it moves further past it, or when it moves back in the opposite direction. It is set again only by a new crossing.
- R6: A 1 on a clear input clears the matching raw bit at the next clock edge.
- R7: If a crossing and a clear arrive in the same cycle, the raw bit ends up set.
- R8: Each interrupt output equals its raw bit AND its mask input, with no added latency.
- R9: Level select codes 5, 6 and 7 behave exactly like code 2, the half-full threshold of 8.
- R10: Once set, a raw bit stays set until it is cleared, whatever the counts do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_count_i | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count_i | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_level_i | input | 3 | Receive threshold select code |
| tx_level_i | input | 3 | Transmit threshold select code |
| rx_mask_i | input | 1 | Arms the receive interrupt output |
| tx_mask_i | input | 1 | Arms the transmit interrupt output |
| rx_clear_i | input | 1 | Write-one-to-clear strobe for receive raw status |
| tx_clear_i | input | 1 | Write-one-to-clear strobe for transmit raw status |
| rx_raw_o | output | 1 | Receive raw status |
| tx_raw_o | output | 1 | Transmit raw status |
| rx_irq_o | output | 1 | Receive interrupt, raw AND mask |
| tx_irq_o | output | 1 | Transmit interrupt, raw AND mask |

## Verification
The assertions assume that each occupancy input stays between 0 and the FIFO depth, as any real FIFO count would. The assertions also assume that a raw bit can rise only in a cycle that follows a detected crossing, and nothing else drives the status registers. The stimulus only ever drives counts from 0 to 16. It changes the level selects and masks in cycles where the counts are held still, so that a select change alone cannot look like a crossing to the reference model. The stimulus walks every threshold code, in both directions, one entry at a time and in large jumps.

// File: rtl/fill_irq_pkg.sv
package fill_irq_pkg;

  typedef enum logic {
    FILL_UP    = 1'b0,
    DRAIN_DOWN = 1'b1
  } fill_dir_e;

  // Rising threshold in eighths of the depth; reserved codes fall back to half.
  function automatic int fill_up_level(input int sel, input int depth);
    case (sel)
      0:       return depth / 8;
      1:       return depth / 4;
      2:       return depth / 2;
      3:       return (depth * 3) / 4;
      4:       return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction

  // Falling threshold mirrors the rising table about the depth.
  function automatic int drain_down_level(input int sel, input int depth);
    return depth - fill_up_level(sel, depth);
  endfunction

endpackage

// File: rtl/level_cross_detect.sv
module level_cross_detect
  import fill_irq_pkg::*;
#(
  parameter int        DEPTH = 16,
  parameter int        CNT_W = $clog2(DEPTH) + 1,
  parameter int        SEL_W = 3,
  parameter fill_dir_e DIR   = FILL_UP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [SEL_W-1:0] level_i,
  output logic             cross_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= count_i;
  end

  generate
    if (DIR == FILL_UP) begin : g_up
      always_comb begin
        thr     = CNT_W'(fill_up_level(int'(level_i), DEPTH));
        cross_o = (prev_q < thr) && (count_i >= thr);
      end
    end else begin : g_down
      always_comb begin
        thr     = CNT_W'(drain_down_level(int'(level_i), DEPTH));
        cross_o = (prev_q > thr) && (count_i <= thr);
      end
    end
  endgenerate

  // R4: jump detection relies on counts staying inside the FIFO range
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count_i <= FULL_CNT);

endmodule

// File: rtl/irq_status_bit.sv
module irq_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clear_i,
  input  logic mask_i,
  output logic raw_o,
  output logic irq_o
);

  logic raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw_q <= 1'b0;
    else if (set_i)   raw_q <= 1'b1;
    else if (clear_i) raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & mask_i;

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> raw_q);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !set_i) |=> !raw_q);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clear_i) |=> raw_q);

  a_r5_rise_needs_cross: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(set_i));

  a_r8_irq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_i && raw_q));

endmodule

// File: rtl/fill_irq_trigger.sv
module fill_irq_trigger
  import fill_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH) + 1,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [SEL_W-1:0] rx_level_i,
  input  logic [SEL_W-1:0] tx_level_i,
  input  logic             rx_mask_i,
  input  logic             tx_mask_i,
  input  logic             rx_clear_i,
  input  logic             tx_clear_i,
  output logic             rx_raw_o,
  output logic             tx_raw_o,
  output logic             rx_irq_o,
  output logic             tx_irq_o
);

  logic rx_cross;
  logic tx_cross;

  level_cross_detect #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .SEL_W(SEL_W), .DIR(FILL_UP)
  ) u_rx_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_i (rx_count_i),
    .level_i (rx_level_i),
    .cross_o (rx_cross)
  );

  level_cross_detect #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .SEL_W(SEL_W), .DIR(DRAIN_DOWN)
  ) u_tx_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_i (tx_count_i),
    .level_i (tx_level_i),
    .cross_o (tx_cross)
  );

  irq_status_bit u_rx_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (rx_cross),
    .clear_i (rx_clear_i),
    .mask_i  (rx_mask_i),
    .raw_o   (rx_raw_o),
    .irq_o   (rx_irq_o)
  );

  irq_status_bit u_tx_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (tx_cross),
    .clear_i (tx_clear_i),
    .mask_i  (tx_mask_i),
    .raw_o   (tx_raw_o),
    .irq_o   (tx_irq_o)
  );

  // R1: nothing is pending in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_raw_o && !tx_raw_o));

endmodule

// File: tb/fill_irq_trigger_test.sv
module fill_irq_trigger_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rx_count_i = '0;
  logic [4:0] tx_count_i = '0;
  logic [2:0] rx_level_i = '0;
  logic [2:0] tx_level_i = '0;
  logic       rx_mask_i = 1'b0;
  logic       tx_mask_i = 1'b0;
  logic       rx_clear_i = 1'b0;
  logic       tx_clear_i = 1'b0;
  logic       rx_raw_o, tx_raw_o, rx_irq_o, tx_irq_o;

  fill_irq_trigger uut (
    .clk(clk), .rst_n(rst_n),
    .rx_count_i(rx_count_i), .tx_count_i(tx_count_i),
    .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
    .rx_mask_i(rx_mask_i), .tx_mask_i(tx_mask_i),
    .rx_clear_i(rx_clear_i), .tx_clear_i(tx_clear_i),
    .rx_raw_o(rx_raw_o), .tx_raw_o(tx_raw_o),
    .rx_irq_o(rx_irq_o), .tx_irq_o(tx_irq_o)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  // reference model state: expected values after the next edge
  logic [4:0] m_prx = '0, m_ptx = '0;
  logic       m_rr = 1'b0, m_tr = 1'b0;

  function automatic int ref_up(input int code);
    case (code)
      0: return 2;  1: return 4;  2: return 8;
      3: return 12; 4: return 14; default: return 8;
    endcase
  endfunction

  function automatic int ref_down(input int code);
    case (code)
      0: return 14; 1: return 12; 2: return 8;
      3: return 4;  4: return 2;  default: return 8;
    endcase
  endfunction

  // driver: apply one cycle of counts and strobes, push expected outputs
  task automatic step(input int rxc, input int txc, input logic rclr,
                      input logic tclr, input string tag);
    logic sr, st;
    @(negedge clk);
    rx_count_i = 5'(rxc);
    tx_count_i = 5'(txc);
    rx_clear_i = rclr;
    tx_clear_i = tclr;
    sr = (int'(m_prx) < ref_up(int'(rx_level_i))) && (rxc >= ref_up(int'(rx_level_i)));
    st = (int'(m_ptx) > ref_down(int'(tx_level_i))) && (txc <= ref_down(int'(tx_level_i)));
    m_rr = sr | (m_rr & ~rclr);
    m_tr = st | (m_tr & ~tclr);
    m_prx = 5'(rxc);
    m_ptx = 5'(txc);
    exp_q.push_back({m_rr, m_tr, m_rr & rx_mask_i, m_tr & tx_mask_i});
    tag_q.push_back(tag);
  endtask

  // change selects and masks while counts hold still and strobes drop
  task automatic setup(input int rl, input int tl, input logic rm, input logic tm);
    @(negedge clk);
    rx_level_i = 3'(rl);
    tx_level_i = 3'(tl);
    rx_mask_i  = rm;
    tx_mask_i  = tm;
    rx_clear_i = 1'b0;
    tx_clear_i = 1'b0;
  endtask

  // monitor: compare after each edge that has an expected item
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      logic [3:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {rx_raw_o, tx_raw_o, rx_irq_o, tx_irq_o};
      vectors++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s: {rx_raw,tx_raw,rx_irq,tx_irq} actual %b expected %b", t, a, e);
      end
    end
  end

  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    vectors++;
    if ({rx_raw_o, tx_raw_o, rx_irq_o, tx_irq_o} !== 4'b0000) begin
      miscompares++;
      $display("FAIL R1 in reset: actual %b expected 0000",
               {rx_raw_o, tx_raw_o, rx_irq_o, tx_irq_o});
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1 first cycle");

    setup(0, 0, 1, 1);
    step(1, 0, 0, 0, "R2 below level");
    step(2, 0, 0, 0, "R2 reach level");
    step(2, 0, 1, 0, "R6 clear");
    step(3, 0, 0, 0, "R5 stay above");
    step(9, 0, 0, 0, "R5 move further");
    step(1, 0, 0, 0, "R5 fall back");
    step(2, 0, 0, 0, "R5 re-cross");
    step(2, 0, 1, 0, "R6 clear again");

    for (int code = 0; code < 5; code++) begin
      setup(code, 0, 1, 1);
      step(0, 0, 1, 0, "R6 clear before ramp");
      for (int c = 1; c <= 16; c++) step(c, 0, 0, 0, "R2 ramp up");
    end
    for (int code = 5; code < 8; code++) begin
      setup(code, code, 1, 1);
      step(0, 16, 1, 1, "R9 clear before ramp");
      for (int c = 1; c <= 16; c++) step(c, 16 - c, 0, 0, "R9 reserved code");
    end

    for (int code = 0; code < 5; code++) begin
      setup(0, code, 1, 1);
      step(0, 16, 1, 1, "R6 clear before drain");
      for (int c = 15; c >= 0; c--) step(0, c, 0, 0, "R3 drain down");
      step(0, 0, 1, 1, "R6 clear after drain");
      step(0, 16, 0, 0, "R5 refill no set");
    end

    setup(2, 2, 1, 1);
    step(0, 16, 1, 1, "R6 clear before jump");
    step(16, 0, 0, 0, "R4 jump crossing");
    step(16, 0, 1, 1, "R6 clear after jump");
    step(5, 9, 0, 0, "R5 reverse jump");
    step(5, 9, 1, 1, "R6 clear held");
    step(10, 3, 1, 1, "R7 set beats clear");
    step(10, 3, 0, 0, "R10 sticky");
    step(0, 16, 0, 0, "R10 sticky after reversal");
    step(4, 12, 0, 0, "R10 sticky mid range");

    setup(2, 2, 0, 0);
    step(4, 12, 0, 0, "R8 both disarmed");
    setup(2, 2, 1, 0);
    step(4, 12, 0, 0, "R8 rx armed only");
    setup(2, 2, 0, 1);
    step(4, 12, 0, 0, "R8 tx armed only");
    step(4, 12, 1, 1, "R6 final clear");

    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule